// File: doc/BRIEF.md
# Interrupt Exception Control Unit

This block decides when a processor core leaves its instruction stream to service an interrupt or a synchronous fault, and keeps the control state that decides it. Six hardware request lines are registered on every clock. Two software request bits sit next to them in a cause register. A status register holds a mask bit for each of the eight requests, a global enable, a user-mode bit and an exception-level flag. At an instruction boundary, a request that is pending, unmasked and globally enabled makes the unit steer fetch to a fixed vector. On the same cycle it cancels the instruction in flight. On the following edge it records the resume PC, writes the exception code and raises the exception level.

While the exception level flag is set, every further interrupt is held off and the core runs in kernel mode, whatever the enable bit and the user-mode bit say. A return strobe clears the flag and sends fetch back to the saved PC. Software reads and writes the status, cause and saved-PC registers through a two-bit select port. A synchronous exception input from the pipeline takes priority over any interrupt that arrives in the same cycle.

Top module: `irq_exc_ctrl`

## Requirements
- R1: After reset the status, cause and saved-PC registers read 0, exl_o is 0, kernel_o is 1 and redirect_o is 0.
- R2: Cause bits [15:10] show hardware lines 5..0 as sampled at the previous rising clock edge. Cause bit 10+k follows line k. Software writes to these bits have no effect.
- R3: redirect_o goes high in the cycle after a line is sampled high when all of the following hold: at least one pending bit has its mask bit set (status bits [15:8], bit 8+i masks pending bit i), IE (status bit 0) is 1, EXL (status bit 1) is 0 and fetch_ok_i is 1.
- R4: Taking an interrupt drives redirect_pc_o to 0x80000180 and raises kill_o in that cycle. At the next edge EXL becomes 1, the saved PC takes cur_pc_i and the code field (cause bits [6:2]) becomes 0.
- R5: While EXL is 1, no interrupt is taken and kernel_o is 1, whatever IE and UM (status bit 4) hold. While EXL is 0, kernel_o equals the inverse of UM.
- R6: While fetch_ok_i is 0, no interrupt is taken, even when a request qualifies.
- R7: When software clears EXL and IE together while a line stays high, no interrupt is taken until IE is set again.
- R8: An eret_i pulse drives redirect_o high with redirect_pc_o equal to the saved PC in the same cycle, leaves kill_o low, and clears EXL at the next edge.
- R9: Cause bits [9:8] are software request bits, written through the register port. They take part in the same mask test as the hardware bits.
- R10: A sync_exc_i pulse is taken in any cycle and beats a simultaneous interrupt. Its code is written to cause bits [6:2], the saved PC and EXL are updated, and the interrupt stays pending.
- R11: Select value 0 addresses status, 1 addresses cause, 2 addresses the saved PC, and 3 reads 0. Status bits other than 0, 1, 4 and [15:8] read 0. The code field cannot be written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hw_irq_i | input | 6 | External interrupt request levels |
| fetch_ok_i | input | 1 | Pipeline is at an instruction boundary |
| cur_pc_i | input | 32 | PC of the next instruction to execute |
| sync_exc_i | input | 1 | Synchronous exception from the pipeline |
| sync_code_i | input | 5 | Exception code of that exception |
| eret_i | input | 1 | Return-from-exception strobe |
| reg_sel_i | input | 2 | Register select for the software port |
| reg_we_i | input | 1 | Register write enable |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| redirect_o | output | 1 | Redirect fetch this cycle |
| redirect_pc_o | output | 32 | Fetch target when redirecting |
| kill_o | output | 1 | Cancel the instruction in flight |
| exl_o | output | 1 | Exception level flag |
| kernel_o | output | 1 | Core runs with kernel privilege |

## Verification
The bench targets the cycle in which a sampled line first causes a redirect. A design with an extra or a missing register on that path shows the redirect one cycle early or late. It checks that clearing EXL while IE is off and the line is still high produces no re-entry; a unit that gated only on EXL would loop straight back into the handler. It drives an interrupt and a synchronous exception together and expects the synchronous code and a still-pending interrupt bit; reversed priority would record code 0. It also writes the hardware pending bits and the code field, and expects both writes to be ignored when the registers are read back.

// File: rtl/irq_exc_pkg.sv
// Package: shared field positions and select codes for the interrupt
// exception control unit. Assumes at most eight request sources so the
// mask and pending fields fit in bits [15:8].
package irq_exc_pkg;
    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_CAUSE  = 2'd1,
        SEL_EPC    = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    localparam int ST_IE    = 0;
    localparam int ST_EXL   = 1;
    localparam int ST_UM    = 4;
    localparam int FLD_LSB  = 8;
    localparam int CODE_LSB = 2;
    localparam int CODE_W   = 5;
    localparam logic [CODE_W-1:0] CODE_INT = '0;
endpackage

// File: rtl/irq_line_sampler.sv
// Module: registers the external request lines through STAGES flops.
// Assumes the lines are already synchronous to clk; STAGES only sets the
// latency (1 by default).
module irq_line_sampler #(
    parameter int W      = 6,
    parameter int STAGES = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lines_i,
    output logic [W-1:0] lines_o
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // first stage: capture the raw levels each cycle
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= lines_i;
            end
        end else begin : g_next
            // later stages: shift the previous sample along
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign lines_o = stage_q[STAGES-1];
endmodule

// File: rtl/irq_take_logic.sv
// Module: chooses what the unit does this cycle. The choices, highest
// priority first, are a synchronous exception, a return, or an interrupt.
// Purely combinational; assumes the pipeline holds fetch_ok_i high only at
// an instruction boundary.
module irq_take_logic #(
    parameter int N = 8
) (
    input  logic [N-1:0] pend_i,
    input  logic [N-1:0] mask_i,
    input  logic         ie_i,
    input  logic         exl_i,
    input  logic         fetch_ok_i,
    input  logic         sync_exc_i,
    input  logic         eret_i,
    output logic         take_irq_o,
    output logic         take_sync_o,
    output logic         take_eret_o
);
    logic qualified;

    // rank the three events and gate interrupts on enable, level and boundary
    always_comb begin
        qualified   = |(pend_i & mask_i) && ie_i && !exl_i;
        take_sync_o = sync_exc_i;
        take_eret_o = eret_i && !sync_exc_i;
        take_irq_o  = qualified && fetch_ok_i && !sync_exc_i && !eret_i;
    end
endmodule

// File: rtl/irq_cp_regs.sv
// Module: status, cause and saved-PC registers with their software port.
// Hardware events override a software write to the same field in the same
// cycle. Assumes FLD_LSB + N_SW + N_HW <= 16 and XLEN >= 16.
module irq_cp_regs
    import irq_exc_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int N_SW = 2,
    parameter int N_HW = 6,
    localparam int N   = N_SW + N_HW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_HW-1:0]   hw_pend_i,
    input  logic              take_irq_i,
    input  logic              take_sync_i,
    input  logic              take_eret_i,
    input  logic [CODE_W-1:0] sync_code_i,
    input  logic [XLEN-1:0]   pc_i,
    input  logic [1:0]        sel_i,
    input  logic              we_i,
    input  logic [XLEN-1:0]   wdata_i,
    output logic [XLEN-1:0]   rdata_o,
    output logic              ie_o,
    output logic              exl_o,
    output logic              um_o,
    output logic [N-1:0]      mask_o,
    output logic [N-1:0]      pend_o,
    output logic [XLEN-1:0]   epc_o
);
    logic              ie_q, exl_q, um_q;
    logic [N-1:0]      mask_q;
    logic [N_SW-1:0]   swp_q;
    logic [CODE_W-1:0] code_q;
    logic [XLEN-1:0]   epc_q;
    logic              wr_st, wr_ca, wr_epc, entry;

    assign wr_st  = we_i && (sel_i == SEL_STATUS);
    assign wr_ca  = we_i && (sel_i == SEL_CAUSE);
    assign wr_epc = we_i && (sel_i == SEL_EPC);
    assign entry  = take_irq_i || take_sync_i;

    // status fields: software write first, hardware events override EXL
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q   <= 1'b0;
            exl_q  <= 1'b0;
            um_q   <= 1'b0;
            mask_q <= '0;
        end else begin
            if (wr_st) begin
                ie_q   <= wdata_i[ST_IE];
                exl_q  <= wdata_i[ST_EXL];
                um_q   <= wdata_i[ST_UM];
                mask_q <= wdata_i[FLD_LSB +: N];
            end
            if (entry)            exl_q <= 1'b1;
            else if (take_eret_i) exl_q <= 1'b0;
        end
    end

    // cause fields: software request bits, and the code written on entry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            swp_q  <= '0;
            code_q <= '0;
        end else begin
            if (wr_ca)            swp_q  <= wdata_i[FLD_LSB +: N_SW];
            if (take_sync_i)      code_q <= sync_code_i;
            else if (take_irq_i)  code_q <= CODE_INT;
        end
    end

    // saved PC: software write, overridden by exception entry
    always_ff @(posedge clk) begin
        if (!rst_n)      epc_q <= '0;
        else if (entry)  epc_q <= pc_i;
        else if (wr_epc) epc_q <= wdata_i;
    end

    // read mux: assemble the addressed register word
    always_comb begin
        rdata_o = '0;
        unique case (sel_i)
            SEL_STATUS: begin
                rdata_o[ST_IE]        = ie_q;
                rdata_o[ST_EXL]       = exl_q;
                rdata_o[ST_UM]        = um_q;
                rdata_o[FLD_LSB +: N] = mask_q;
            end
            SEL_CAUSE: begin
                rdata_o[CODE_LSB +: CODE_W] = code_q;
                rdata_o[FLD_LSB +: N]       = {hw_pend_i, swp_q};
            end
            SEL_EPC:  rdata_o = epc_q;
            default:  rdata_o = '0;
        endcase
    end

    assign ie_o   = ie_q;
    assign exl_o  = exl_q;
    assign um_o   = um_q;
    assign mask_o = mask_q;
    assign pend_o = {hw_pend_i, swp_q};
    assign epc_o  = epc_q;
endmodule

// File: rtl/irq_exc_ctrl.sv
// Module: interrupt exception control unit (top). Samples the request lines,
// decides entry or return, and drives the fetch redirect. Assumes the
// pipeline acts on redirect_o and kill_o in the cycle they are high.
module irq_exc_ctrl
    import irq_exc_pkg::*;
#(
    parameter int XLEN        = 32,
    parameter int N_HW        = 6,
    parameter int N_SW        = 2,
    parameter int SYNC_STAGES = 1,
    parameter logic [XLEN-1:0] EXC_VECTOR = 32'h8000_0180
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_HW-1:0]   hw_irq_i,
    input  logic              fetch_ok_i,
    input  logic [XLEN-1:0]   cur_pc_i,
    input  logic              sync_exc_i,
    input  logic [CODE_W-1:0] sync_code_i,
    input  logic              eret_i,
    input  logic [1:0]        reg_sel_i,
    input  logic              reg_we_i,
    input  logic [XLEN-1:0]   reg_wdata_i,
    output logic [XLEN-1:0]   reg_rdata_o,
    output logic              redirect_o,
    output logic [XLEN-1:0]   redirect_pc_o,
    output logic              kill_o,
    output logic              exl_o,
    output logic              kernel_o
);
    localparam int N = N_SW + N_HW;

    logic [N_HW-1:0] hw_pend;
    logic [N-1:0]    pend, mask;
    logic [XLEN-1:0] epc;
    logic            ie, exl, um;
    logic            take_irq, take_sync, take_eret;

    irq_line_sampler #(.W(N_HW), .STAGES(SYNC_STAGES)) u_sampler (
        .clk(clk), .rst_n(rst_n), .lines_i(hw_irq_i), .lines_o(hw_pend)
    );

    irq_take_logic #(.N(N)) u_take (
        .pend_i(pend), .mask_i(mask), .ie_i(ie), .exl_i(exl),
        .fetch_ok_i(fetch_ok_i), .sync_exc_i(sync_exc_i), .eret_i(eret_i),
        .take_irq_o(take_irq), .take_sync_o(take_sync), .take_eret_o(take_eret)
    );

    irq_cp_regs #(.XLEN(XLEN), .N_SW(N_SW), .N_HW(N_HW)) u_regs (
        .clk(clk), .rst_n(rst_n), .hw_pend_i(hw_pend),
        .take_irq_i(take_irq), .take_sync_i(take_sync), .take_eret_i(take_eret),
        .sync_code_i(sync_code_i), .pc_i(cur_pc_i),
        .sel_i(reg_sel_i), .we_i(reg_we_i), .wdata_i(reg_wdata_i),
        .rdata_o(reg_rdata_o), .ie_o(ie), .exl_o(exl), .um_o(um),
        .mask_o(mask), .pend_o(pend), .epc_o(epc)
    );

    // redirect path: vector on entry, saved PC on return
    always_comb begin
        redirect_o    = take_irq || take_sync || take_eret;
        kill_o        = take_irq || take_sync;
        redirect_pc_o = take_eret ? epc : EXC_VECTOR;
    end

    assign exl_o    = exl;
    assign kernel_o = exl || !um;
endmodule

// File: rtl/irq_exc_chk.sv
// Module: assertion checker for irq_exc_ctrl, bound below. Observes ports
// only and assumes the same vector parameter as the unit.
module irq_exc_chk #(
    parameter int XLEN = 32,
    parameter logic [XLEN-1:0] EXC_VECTOR = 32'h8000_0180
) (
    input logic            clk,
    input logic            rst_n,
    input logic            fetch_ok_i,
    input logic            sync_exc_i,
    input logic            eret_i,
    input logic            redirect_o,
    input logic [XLEN-1:0] redirect_pc_o,
    input logic            kill_o,
    input logic            exl_o,
    input logic            kernel_o
);
    p_vec_on_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        kill_o |-> (redirect_o && redirect_pc_o == EXC_VECTOR));
    p_exl_after_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        kill_o |=> exl_o);
    p_exl_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (exl_o && !sync_exc_i && !eret_i) |-> !redirect_o);
    p_kernel_in_exl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        exl_o |-> kernel_o);
    p_fetch_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_ok_i && !sync_exc_i && !eret_i) |-> !redirect_o);
    p_eret_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (eret_i && !sync_exc_i) |=> !exl_o);
    p_eret_no_kill_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (eret_i && !sync_exc_i) |-> (redirect_o && !kill_o));
    p_sync_taken_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sync_exc_i |-> kill_o);
endmodule

bind irq_exc_ctrl irq_exc_chk #(.XLEN(XLEN), .EXC_VECTOR(EXC_VECTOR)) u_chk (
    .clk(clk), .rst_n(rst_n), .fetch_ok_i(fetch_ok_i), .sync_exc_i(sync_exc_i),
    .eret_i(eret_i), .redirect_o(redirect_o), .redirect_pc_o(redirect_pc_o),
    .kill_o(kill_o), .exl_o(exl_o), .kernel_o(kernel_o)
);

// File: tb/irq_exc_ctrl_tb.sv
// Directed bench for irq_exc_ctrl: one task per scenario, each checking itself.
module irq_exc_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  hw_irq_i = '0;
    logic        fetch_ok_i = 1'b1;
    logic [31:0] cur_pc_i = '0;
    logic        sync_exc_i = 1'b0;
    logic [4:0]  sync_code_i = '0;
    logic        eret_i = 1'b0;
    logic [1:0]  reg_sel_i = '0;
    logic        reg_we_i = 1'b0;
    logic [31:0] reg_wdata_i = '0;
    logic [31:0] reg_rdata_o, redirect_pc_o;
    logic        redirect_o, kill_o, exl_o, kernel_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    localparam logic [31:0] VEC = 32'h8000_0180;

    irq_exc_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .hw_irq_i(hw_irq_i), .fetch_ok_i(fetch_ok_i),
        .cur_pc_i(cur_pc_i), .sync_exc_i(sync_exc_i), .sync_code_i(sync_code_i),
        .eret_i(eret_i), .reg_sel_i(reg_sel_i), .reg_we_i(reg_we_i),
        .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
        .redirect_o(redirect_o), .redirect_pc_o(redirect_pc_o), .kill_o(kill_o),
        .exl_o(exl_o), .kernel_o(kernel_o)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; hw_irq_i = '0; fetch_ok_i = 1'b1; sync_exc_i = 1'b0;
        eret_i = 1'b0; reg_we_i = 1'b0; cur_pc_i = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        reg_sel_i = sel; reg_wdata_i = d; reg_we_i = 1'b1;
        @(negedge clk);
        reg_we_i = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [31:0] d);
        reg_sel_i = sel;
        #1 d = reg_rdata_o;
    endtask

    // R1: reset values
    task automatic t_reset();
        logic [31:0] d;
        do_reset();
        rd(2'd0, d); check("R1 status", d, 32'h0);
        rd(2'd1, d); check("R1 cause", d, 32'h0);
        rd(2'd2, d); check("R1 epc", d, 32'h0);
        check("R1 exl", {31'b0, exl_o}, 32'h0);
        check("R1 kernel", {31'b0, kernel_o}, 32'h1);
        check("R1 redirect", {31'b0, redirect_o}, 32'h0);
    endtask

    // R3 R4 R2 R8: hardware entry timing, effects, then return
    task automatic t_entry_and_return();
        logic [31:0] d;
        do_reset();
        wr(2'd0, 32'h0000_0401);            // IE, mask bit for line 0
        cur_pc_i = 32'h0000_1000;
        hw_irq_i = 6'b000001;
        #1 check("R3 no redirect before sample", {31'b0, redirect_o}, 32'h0);
        @(negedge clk);
        check("R3 redirect after sample", {31'b0, redirect_o}, 32'h1);
        check("R4 vector", redirect_pc_o, VEC);
        check("R4 kill", {31'b0, kill_o}, 32'h1);
        @(negedge clk);
        check("R4 exl set", {31'b0, exl_o}, 32'h1);
        check("R5 held off in exl", {31'b0, redirect_o}, 32'h0);
        rd(2'd2, d); check("R4 epc", d, 32'h0000_1000);
        rd(2'd1, d); check("R4 code 0 and R2 pending", d, 32'h0000_0400);
        hw_irq_i = '0;
        @(negedge clk);
        rd(2'd1, d); check("R2 pending follows line low", d, 32'h0);
        eret_i = 1'b1;
        #1;
        check("R8 redirect", {31'b0, redirect_o}, 32'h1);
        check("R8 target epc", redirect_pc_o, 32'h0000_1000);
        check("R8 no kill", {31'b0, kill_o}, 32'h0);
        @(negedge clk);
        eret_i = 1'b0;
        check("R8 exl cleared", {31'b0, exl_o}, 32'h0);
        #1 check("R8 no re-entry", {31'b0, redirect_o}, 32'h0);
    endtask

    // R7: clearing EXL with IE off while the line stays high
    task automatic t_exl_clear_ie_off();
        do_reset();
        wr(2'd0, 32'h0000_0401);
        hw_irq_i = 6'b000001;
        repeat (2) @(negedge clk);
        check("R7 entered", {31'b0, exl_o}, 32'h1);
        wr(2'd0, 32'h0000_0400);            // clear IE and EXL, keep mask
        for (int i = 0; i < 3; i++) begin
            #1 check("R7 no interrupt with IE off", {31'b0, redirect_o}, 32'h0);
            @(negedge clk);
        end
        wr(2'd0, 32'h0000_0401);
        check("R7 taken once IE set", {31'b0, redirect_o}, 32'h1);
        hw_irq_i = '0;
    endtask

    // R3: masked line and disabled IE produce nothing
    task automatic t_mask_and_enable();
        logic [31:0] d;
        do_reset();
        wr(2'd0, 32'h0000_0801);            // IE, mask bit for line 1 only
        hw_irq_i = 6'b000001;
        repeat (3) @(negedge clk);
        check("R3 masked line ignored", {31'b0, redirect_o}, 32'h0);
        rd(2'd1, d); check("R2 pending while masked", d, 32'h0000_0400);
        wr(2'd0, 32'h0000_0400);            // mask set, IE off
        repeat (2) @(negedge clk);
        check("R3 IE off ignored", {31'b0, redirect_o}, 32'h0);
        hw_irq_i = '0;
    endtask

    // R6: no entry while fetch boundary is absent
    task automatic t_fetch_gate();
        do_reset();
        wr(2'd0, 32'h0000_0401);
        fetch_ok_i = 1'b0;
        hw_irq_i = 6'b000001;
        repeat (3) @(negedge clk);
        check("R6 held off", {31'b0, redirect_o}, 32'h0);
        fetch_ok_i = 1'b1;
        #1 check("R6 taken at boundary", {31'b0, redirect_o}, 32'h1);
        hw_irq_i = '0;
    endtask

    // R9 R2 R11: software request bits, and ignored writes
    task automatic t_software_bits();
        logic [31:0] d;
        do_reset();
        wr(2'd1, 32'h0000_FC7C);            // hw pending bits and code field
        rd(2'd1, d); check("R2 R11 hw pending and code not writable", d, 32'h0);
        wr(2'd0, 32'h0000_0101);            // IE, mask bit 0
        wr(2'd1, 32'h0000_0100);            // software request 0
        check("R9 software request taken", {31'b0, redirect_o}, 32'h1);
        @(negedge clk);
        rd(2'd1, d); check("R9 software bit reads back", d, 32'h0000_0100);
    endtask

    // R10: synchronous exception beats a simultaneous interrupt
    task automatic t_sync_priority();
        logic [31:0] d;
        do_reset();
        wr(2'd0, 32'h0000_0401);
        hw_irq_i = 6'b000001;
        @(negedge clk);
        sync_exc_i = 1'b1; sync_code_i = 5'd4; cur_pc_i = 32'h0000_2000;
        #1 check("R10 kill", {31'b0, kill_o}, 32'h1);
        @(negedge clk);
        sync_exc_i = 1'b0;
        check("R10 exl", {31'b0, exl_o}, 32'h1);
        rd(2'd1, d); check("R10 code 4, irq still pending", d, 32'h0000_0410);
        rd(2'd2, d); check("R10 epc", d, 32'h0000_2000);
        hw_irq_i = '0;
    endtask

    // R5 R11: privilege and register layout
    task automatic t_privilege_and_port();
        logic [31:0] d;
        do_reset();
        wr(2'd0, 32'h0000_0010);
        check("R5 user mode", {31'b0, kernel_o}, 32'h0);
        wr(2'd0, 32'h0000_0413);            // IE, EXL, UM, mask bit 2
        check("R5 exl forces kernel", {31'b0, kernel_o}, 32'h1);
        hw_irq_i = 6'b000001;
        repeat (3) @(negedge clk);
        check("R5 exl blocks despite IE", {31'b0, redirect_o}, 32'h0);
        hw_irq_i = '0;
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, d); check("R11 status layout", d, 32'h0000_FF13);
        wr(2'd2, 32'hCAFE_0004);
        rd(2'd2, d); check("R11 epc write", d, 32'hCAFE_0004);
        rd(2'd3, d); check("R11 select 3 reads zero", d, 32'h0);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_entry_and_return();
        t_exl_clear_ie_off();
        t_mask_and_enable();
        t_fetch_gate();
        t_software_bits();
        t_sync_priority();
        t_privilege_and_port();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule